// File: doc/BRIEF.md
# Debug breakpoint status unit

This unit watches the processor's per-cycle debug events and decides when a debug exception must be raised. It keeps four linear-address breakpoint slots, a control register with a local and a global enable per slot plus a per-slot access type and length, and a sticky status register that records the reasons for the most recent exceptions. Instruction-fetch matches are reported as faults; data-access matches, single-step traps and task-switch traps are reported as traps. A guard bit in the control register turns any software access to the debug registers into a fault and then disarms itself, so the exception handler can reach the registers.

The pipeline presents, in any cycle, an instruction-fetch start address, a data access (address, size, direction), a single-step trap indication, a task switch (with the new task's trap bit), and a software register access. One clock later the unit presents a one-cycle exception request with a fault/trap qualifier, and the status register holds every cause seen in that cycle. Status bits are only cleared by a software write.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: A data access of size code 00/01/11 (1/2/4 bytes) at address a matches a slot with length code 00/01/11 (1/2/4 bytes) when the access bytes [a, a+size-1] overlap the slot range starting at the slot address with its low bits cleared to the length's alignment; an enabled data match sets status bit i (bit i for slot i) and raises exc_req with exc_is_fault=0 on the next cycle.
- R2: An execute slot (access type 00) matches only when its length code is 00 and the fetch start address equals the slot address exactly; an enabled match raises exc_req with exc_is_fault=1 and sets status bit i.
- R3: While resume_flag is high, instruction-fetch matches are suppressed entirely.
- R4: When at least one enabled slot matches, the status bit of every matching slot is set, enabled or not; matches on disabled slots alone raise nothing and set nothing.
- R5: Access type 01 matches data writes only, 11 matches reads and writes, 10 never matches.
- R6: Status bits are sticky: hardware only sets them; a software write to register 6 replaces the status value.
- R7: A task switch clears the four local enable bits (control bits 3:0) and leaves the global enable bits (7:4) unchanged.
- R8: A task switch with the trap bit set raises a trap and sets status bit 15.
- R9: A single-step trap raises a trap and sets status bit 14.
- R10: With the guard bit (control bit 8) set, any register access is not performed, raises a fault, sets status bit 13, and clears the guard bit.
- R11: The exception request lasts one cycle per event cycle; all trap causes of one cycle are recorded together, and exc_is_fault is high only with exc_req.
- R12: After reset every register reads zero and no exception is requested.
- R13: Register index 0-3 selects slot addresses, 6 the status and 7 the control (slot i type at bits 16+4i, length at 18+4i); other indices read zero and ignore writes; read data appears one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Instruction fetch start this cycle |
| fetch_addr | input | W | Fetch start linear address |
| resume_flag | input | 1 | Suppress instruction breakpoints |
| data_vld | input | 1 | Data access this cycle |
| data_addr | input | W | Data access linear address |
| data_size | input | 2 | Access size code (00=1, 01=2, 11=4 bytes) |
| data_wr | input | 1 | 1 for write, 0 for read |
| step_trap | input | 1 | Single-step trap pending |
| tsw_vld | input | 1 | Task switch this cycle |
| tsw_trap_bit | input | 1 | New task has its trap bit set |
| reg_req | input | 1 | Software register access |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data (registered) |
| exc_req | output | 1 | Debug exception request pulse |
| exc_is_fault | output | 1 | 1 fault, 0 trap |

## Verification
Every cycle the assertions check that status bits never drop without a software write, that a task switch clears the local enables while holding the global ones, that a guarded access disarms the guard and records its flag, that a single step always reaches the status and request, that reserved-type slots never match and that disabled-only matches stay silent. Only the bench scenarios show the arithmetic overlap rule across all length and size combinations, exact-address execute matching and its suppression, the register map and read-back, and the combination of simultaneous trap causes in one status value.

// File: rtl/dbg_bkpt_pkg.sv
`timescale 1ns/100ps
package dbg_bkpt_pkg;
  typedef enum logic [1:0] {
    ACC_EXEC = 2'b00,
    ACC_WR   = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_RW   = 2'b11
  } acc_e;

  localparam logic [2:0] IDX_STATUS = 3'd6;
  localparam logic [2:0] IDX_CTRL   = 3'd7;
  localparam int FLD_BASE = 16;
  localparam int ST_GUARD = 13;
  localparam int ST_STEP  = 14;
  localparam int ST_TSW   = 15;

  function automatic logic [2:0] span_m1(input logic [1:0] code);
    case (code)
      2'b01:   span_m1 = 3'd1;
      2'b11:   span_m1 = 3'd3;
      default: span_m1 = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_slot_match.sv
`timescale 1ns/100ps
module dbg_slot_match import dbg_bkpt_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] bp_addr,
  input  acc_e         acc,
  input  logic [1:0]   len,
  input  logic         fetch_vld,
  input  logic [W-1:0] fetch_addr,
  input  logic         resume_flag,
  input  logic         data_vld,
  input  logic [W-1:0] data_addr,
  input  logic [1:0]   data_size,
  input  logic         data_wr,
  output logic         hit_exec,
  output logic         hit_data
);
  logic [2:0] bp_m1, ac_m1;
  logic [W-1:0] bp_base;
  logic [W:0] bp_end, ac_lo, ac_hi;
  logic overlap, dir_ok;

  always_comb begin
    bp_m1   = span_m1(len);
    ac_m1   = span_m1(data_size);
    bp_base = bp_addr & ~W'(bp_m1);
    bp_end  = {1'b0, bp_base} + (W+1)'(bp_m1);
    ac_lo   = {1'b0, data_addr};
    ac_hi   = ac_lo + (W+1)'(ac_m1);
    overlap = (ac_lo <= bp_end) && (ac_hi >= {1'b0, bp_base});
    dir_ok  = (acc == ACC_RW) || ((acc == ACC_WR) && data_wr);
    hit_data = data_vld && overlap && dir_ok;
    hit_exec = fetch_vld && !resume_flag && (acc == ACC_EXEC) &&
               (len == 2'b00) && (fetch_addr == bp_addr);
  end
endmodule

// File: rtl/dbg_cause_merge.sv
`timescale 1ns/100ps
module dbg_cause_merge #(
  parameter int NSLOT = 4
) (
  input  logic [NSLOT-1:0] hit_exec,
  input  logic [NSLOT-1:0] hit_data,
  input  logic [NSLOT-1:0] slot_en,
  input  logic             step_trap,
  input  logic             tsw_trap,
  input  logic             guard_hit,
  output logic [NSLOT-1:0] set_b,
  output logic             set_guard,
  output logic             set_step,
  output logic             set_tsw,
  output logic             raise,
  output logic             fault
);
  logic [NSLOT-1:0] any_hit;
  logic armed, trap;

  always_comb begin
    any_hit   = hit_exec | hit_data;
    armed     = |(any_hit & slot_en);
    set_b     = armed ? any_hit : '0;
    fault     = guard_hit | (|(hit_exec & slot_en));
    trap      = (|(hit_data & slot_en)) | step_trap | tsw_trap;
    raise     = fault | trap;
    set_guard = guard_hit;
    set_step  = step_trap;
    set_tsw   = tsw_trap;
  end
endmodule

// File: rtl/dbg_bkpt_unit.sv
`timescale 1ns/100ps
module dbg_bkpt_unit import dbg_bkpt_pkg::*; #(
  parameter int W     = 32,
  parameter int NSLOT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fetch_vld,
  input  logic [W-1:0] fetch_addr,
  input  logic         resume_flag,
  input  logic         data_vld,
  input  logic [W-1:0] data_addr,
  input  logic [1:0]   data_size,
  input  logic         data_wr,
  input  logic         step_trap,
  input  logic         tsw_vld,
  input  logic         tsw_trap_bit,
  input  logic         reg_req,
  input  logic         reg_wr,
  input  logic [2:0]   reg_idx,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         exc_req,
  output logic         exc_is_fault
);
  localparam int GEN_BASE = NSLOT;
  localparam int GD_BIT   = 2 * NSLOT;
  localparam int IW       = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  function automatic logic [W-1:0] ctrl_mask();
    logic [W-1:0] m = '0;
    for (int i = 0; i <= GD_BIT; i++) m[i] = 1'b1;
    for (int s = 0; s < NSLOT; s++) m[FLD_BASE + 4*s +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [W-1:0] stat_mask();
    logic [W-1:0] m = '0;
    for (int i = 0; i < NSLOT; i++) m[i] = 1'b1;
    m[ST_GUARD] = 1'b1;
    m[ST_STEP]  = 1'b1;
    m[ST_TSW]   = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] CMASK = ctrl_mask();
  localparam logic [W-1:0] SMASK = stat_mask();

  logic [W-1:0] bp_addr_q [NSLOT];
  logic [W-1:0] ctrl_q, status_q, rdata_q;
  logic         exc_q, fault_q;

  logic [NSLOT-1:0] local_en, glob_en, slot_en, hit_exec, hit_data, set_b;
  logic set_guard, set_step, set_tsw, raise, fault;
  logic guard_hit, sw_wr, sw_rd, wr_ctrl, wr_stat;
  logic [W-1:0] ctrl_d, status_d, rd_mux;

  assign local_en = ctrl_q[NSLOT-1:0];
  assign glob_en  = ctrl_q[GEN_BASE +: NSLOT];
  assign slot_en  = local_en | glob_en;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      dbg_slot_match #(.W(W)) u_cmp (
        .bp_addr     (bp_addr_q[g]),
        .acc         (acc_e'(ctrl_q[FLD_BASE + 4*g +: 2])),
        .len         (ctrl_q[FLD_BASE + 4*g + 2 +: 2]),
        .fetch_vld   (fetch_vld),
        .fetch_addr  (fetch_addr),
        .resume_flag (resume_flag),
        .data_vld    (data_vld),
        .data_addr   (data_addr),
        .data_size   (data_size),
        .data_wr     (data_wr),
        .hit_exec    (hit_exec[g]),
        .hit_data    (hit_data[g])
      );
    end
  endgenerate

  dbg_cause_merge #(.NSLOT(NSLOT)) u_cause (
    .hit_exec  (hit_exec),
    .hit_data  (hit_data),
    .slot_en   (slot_en),
    .step_trap (step_trap),
    .tsw_trap  (tsw_vld & tsw_trap_bit),
    .guard_hit (guard_hit),
    .set_b     (set_b),
    .set_guard (set_guard),
    .set_step  (set_step),
    .set_tsw   (set_tsw),
    .raise     (raise),
    .fault     (fault)
  );

  always_comb begin
    guard_hit = reg_req && ctrl_q[GD_BIT];
    sw_wr     = reg_req && reg_wr && !ctrl_q[GD_BIT];
    sw_rd     = reg_req && !reg_wr && !ctrl_q[GD_BIT];
    wr_ctrl   = sw_wr && (reg_idx == IDX_CTRL);
    wr_stat   = sw_wr && (reg_idx == IDX_STATUS);

    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = reg_wdata & CMASK;
    if (tsw_vld) ctrl_d[NSLOT-1:0] = '0;
    if (guard_hit) ctrl_d[GD_BIT] = 1'b0;

    status_d = status_q;
    if (wr_stat) status_d = reg_wdata & SMASK;
    status_d[NSLOT-1:0] = status_d[NSLOT-1:0] | set_b;
    if (set_guard) status_d[ST_GUARD] = 1'b1;
    if (set_step)  status_d[ST_STEP]  = 1'b1;
    if (set_tsw)   status_d[ST_TSW]   = 1'b1;

    rd_mux = '0;
    if (int'(reg_idx) < NSLOT) rd_mux = bp_addr_q[reg_idx[IW-1:0]];
    else if (reg_idx == IDX_STATUS) rd_mux = status_q;
    else if (reg_idx == IDX_CTRL) rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) bp_addr_q[i] <= '0;
      ctrl_q   <= '0;
      status_q <= '0;
      rdata_q  <= '0;
      exc_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (sw_wr && int'(reg_idx) < NSLOT) bp_addr_q[reg_idx[IW-1:0]] <= reg_wdata;
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
      if (sw_rd) rdata_q <= rd_mux;
      exc_q    <= raise;
      fault_q  <= fault;
    end
  end

  assign reg_rdata    = rdata_q;
  assign exc_req      = exc_q;
  assign exc_is_fault = fault_q;

  // Status bits only drop through a software write (R6)
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_local_clear_R7: assert property (@(posedge clk) disable iff (rst)
    tsw_vld |=> (ctrl_q[NSLOT-1:0] == '0));

  assert_global_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (tsw_vld && !wr_ctrl) |=> $stable(ctrl_q[GEN_BASE +: NSLOT]));

  assert_guard_disarm_R10: assert property (@(posedge clk) disable iff (rst)
    guard_hit |=> (!ctrl_q[GD_BIT] && status_q[ST_GUARD] && exc_req && exc_is_fault));

  assert_step_flag_R9: assert property (@(posedge clk) disable iff (rst)
    step_trap |=> (exc_req && status_q[ST_STEP]));

  assert_fault_qual_R11: assert property (@(posedge clk) disable iff (rst)
    exc_is_fault |-> exc_req);

  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (((hit_exec | hit_data) & slot_en) == '0 && !step_trap && !tsw_vld && !reg_req)
      |=> !exc_req);

  generate
    for (g = 0; g < NSLOT; g++) begin : g_chk
      assert_rsvd_type_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[FLD_BASE + 4*g +: 2] == 2'b10) |-> !(hit_exec[g] || hit_data[g]));
    end
  endgenerate
endmodule

// File: tb/sim_dbg_bkpt_unit.sv
`timescale 1ns/100ps
module sim_dbg_bkpt_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic fetch_vld = 0, resume_flag = 0, data_vld = 0, data_wr = 0;
  logic step_trap = 0, tsw_vld = 0, tsw_trap_bit = 0, reg_req = 0, reg_wr = 0;
  logic [31:0] fetch_addr = 0, data_addr = 0, reg_wdata = 0;
  logic [1:0]  data_size = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_rdata;
  logic exc_req, exc_is_fault;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dbg_bkpt_unit #(.W(32), .NSLOT(4)) u0 (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr_in();
    fetch_vld = 0; resume_flag = 0; data_vld = 0; data_wr = 0;
    step_trap = 0; tsw_vld = 0; tsw_trap_bit = 0; reg_req = 0; reg_wr = 0;
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [31:0] v);
    reg_req = 1; reg_wr = 1; reg_idx = idx; reg_wdata = v;
    tick(); clr_in();
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] v);
    reg_req = 1; reg_wr = 0; reg_idx = idx;
    tick(); v = reg_rdata; clr_in();
  endtask

  task automatic daccess(input logic [31:0] a, input logic [1:0] sz, input logic wr);
    data_vld = 1; data_addr = a; data_size = sz; data_wr = wr;
    tick(); clr_in();
  endtask

  task automatic fetch(input logic [31:0] a, input logic rf);
    fetch_vld = 1; fetch_addr = a; resume_flag = rf;
    tick(); clr_in();
  endtask

  // slot s fields: type at 16+4s, length at 18+4s
  function automatic logic [31:0] fld(input int s, input logic [1:0] t, input logic [1:0] l);
    return (32'(t) << (16 + 4*s)) | (32'(l) << (18 + 4*s));
  endfunction

  logic [31:0] v, ctl;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 exc after reset", {31'd0, exc_req}, 32'd0);
    chk("R12 rdata after reset", reg_rdata, 32'd0);
    rd_reg(3'd7, v); chk("R12 ctrl reset", v, 0);
    rd_reg(3'd6, v); chk("R12 status reset", v, 0);
    rd_reg(3'd2, v); chk("R12 slot addr reset", v, 0);

    // R13 register map
    wr_reg(3'd3, 32'hCAFE0123);
    rd_reg(3'd3, v); chk("R13 slot3 readback", v, 32'hCAFE0123);
    wr_reg(3'd4, 32'h12345678);
    rd_reg(3'd4, v); chk("R13 idx4 reads zero", v, 0);
    wr_reg(3'd5, 32'h12345678);
    rd_reg(3'd5, v); chk("R13 idx5 reads zero", v, 0);
    rd_reg(3'd3, v); chk("R13 unmapped write ignored", v, 32'hCAFE0123);

    // R1 overlap sweep on slot 0 (global enable), others reserved type
    for (int li = 0; li < 3; li++) begin
      logic [1:0] lc = (li == 0) ? 2'b00 : (li == 1) ? 2'b01 : 2'b11;
      ctl = 32'h10 | fld(0, 2'b11, lc) | fld(1, 2'b10, 0) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0);
      wr_reg(3'd7, ctl);
      wr_reg(3'd0, 32'h1006);
      for (int si = 0; si < 3; si++) begin
        logic [1:0] sc = (si == 0) ? 2'b00 : (si == 1) ? 2'b01 : 2'b11;
        for (int off = -5; off <= 5; off++) begin
          logic [31:0] a, bb, be, hi;
          logic exp;
          a  = 32'h1004 + off;
          bb = 32'h1006 & ~(32'(lc));
          be = bb + 32'(lc);
          hi = a + 32'(sc);
          exp = (a <= be) && (hi >= bb);
          daccess(a, sc, off[0]);
          chk($sformatf("R1 exc len=%0d size=%0d addr=%h", lc, sc, a), {31'd0, exc_req}, {31'd0, exp});
          if (exp) chk("R1 trap qualifier", {31'd0, exc_is_fault}, 0);
          @(negedge clk);
          chk("R11 pulse ends", {31'd0, exc_req}, 0);
          rd_reg(3'd6, v);
          chk("R1 status bit0", v, {31'd0, exp});
          wr_reg(3'd6, 0);
        end
      end
    end

    // R5 access types
    wr_reg(3'd7, 32'h10 | fld(0, 2'b01, 0) | fld(1, 2'b10, 0) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0));
    daccess(32'h1006, 2'b00, 1'b0);
    chk("R5 write-only ignores read", {31'd0, exc_req}, 0);
    daccess(32'h1006, 2'b00, 1'b1);
    chk("R5 write-only matches write", {31'd0, exc_req}, 1);
    wr_reg(3'd7, 32'h10 | fld(0, 2'b10, 0) | fld(1, 2'b10, 0) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0));
    daccess(32'h1006, 2'b00, 1'b1);
    chk("R5 reserved never matches", {31'd0, exc_req}, 0);
    wr_reg(3'd6, 0);

    // R2/R3 execute slot 1
    wr_reg(3'd1, 32'h2000);
    wr_reg(3'd7, 32'h20 | fld(0, 2'b10, 0) | fld(1, 2'b00, 0) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0));
    fetch(32'h2000, 0);
    chk("R2 exec match raises", {31'd0, exc_req}, 1);
    chk("R2 exec is fault", {31'd0, exc_is_fault}, 1);
    rd_reg(3'd6, v); chk("R2 status bit1", v, 32'h2);
    wr_reg(3'd6, 0);
    fetch(32'h2001, 0);
    chk("R2 off-address no match", {31'd0, exc_req}, 0);
    fetch(32'h2000, 1);
    chk("R3 resume suppresses", {31'd0, exc_req}, 0);
    rd_reg(3'd6, v); chk("R3 no status under resume", v, 0);
    daccess(32'h2000, 2'b00, 1'b1);
    chk("R2 exec slot ignores data", {31'd0, exc_req}, 0);
    wr_reg(3'd7, 32'h20 | fld(0, 2'b10, 0) | fld(1, 2'b00, 2'b01) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0));
    fetch(32'h2000, 0);
    chk("R2 exec needs length 00", {31'd0, exc_req}, 0);

    // R4 enabled match latches disabled matches too
    wr_reg(3'd0, 32'h3000);
    wr_reg(3'd2, 32'h3000);
    wr_reg(3'd7, 32'h10 | fld(0, 2'b11, 0) | fld(1, 2'b10, 0) | fld(2, 2'b11, 2'b11) | fld(3, 2'b10, 0));
    wr_reg(3'd6, 0);
    daccess(32'h3000, 2'b00, 1'b1);
    chk("R4 enabled match raises", {31'd0, exc_req}, 1);
    rd_reg(3'd6, v); chk("R4 both matching flags", v, 32'h5);
    wr_reg(3'd6, 0);
    daccess(32'h3002, 2'b00, 1'b1);
    chk("R4 disabled-only silent", {31'd0, exc_req}, 0);
    rd_reg(3'd6, v); chk("R4 disabled-only no flag", v, 0);

    // R9/R11 simultaneous causes, R6 sticky
    step_trap = 1; data_vld = 1; data_addr = 32'h3000; data_size = 0; data_wr = 0;
    tick(); clr_in();
    chk("R11 combined raise", {31'd0, exc_req}, 1);
    chk("R9 step is trap", {31'd0, exc_is_fault}, 0);
    rd_reg(3'd6, v); chk("R9 R11 combined status", v, 32'h4005);
    step_trap = 1; tick(); clr_in();
    rd_reg(3'd6, v); chk("R6 prior flags kept", v, 32'h4005);
    wr_reg(3'd6, 32'h0000_8001);
    rd_reg(3'd6, v); chk("R6 software write replaces", v, 32'h8001);
    wr_reg(3'd6, 0);
    rd_reg(3'd6, v); chk("R6 software clear", v, 0);

    // R7/R8 task switch
    ctl = 32'hC3 | fld(0, 2'b10, 0) | fld(1, 2'b10, 0) | fld(2, 2'b10, 0) | fld(3, 2'b10, 0);
    wr_reg(3'd7, ctl);
    tsw_vld = 1; tick(); clr_in();
    chk("R7 plain switch no exc", {31'd0, exc_req}, 0);
    rd_reg(3'd7, v); chk("R7 locals cleared globals kept", v, ctl & ~32'hF);
    tsw_vld = 1; tsw_trap_bit = 1; tick(); clr_in();
    chk("R8 switch trap raises", {31'd0, exc_req}, 1);
    chk("R8 switch is trap", {31'd0, exc_is_fault}, 0);
    rd_reg(3'd6, v); chk("R8 status bit15", v, 32'h8000);
    wr_reg(3'd6, 0);

    // R10 guard
    wr_reg(3'd0, 32'h1111);
    ctl = 32'h100 | fld(1, 2'b10, 0);
    wr_reg(3'd7, ctl);
    wr_reg(3'd0, 32'hDEAD);
    chk("R10 guarded write faults", {31'd0, exc_req}, 1);
    chk("R10 fault qualifier", {31'd0, exc_is_fault}, 1);
    rd_reg(3'd0, v); chk("R10 guarded write blocked", v, 32'h1111);
    rd_reg(3'd7, v); chk("R10 guard cleared", v, ctl & ~32'h100);
    rd_reg(3'd6, v); chk("R10 status bit13", v, 32'h2000);
    wr_reg(3'd7, ctl);
    rd_reg(3'd0, v);
    chk("R10 guarded read faults", {31'd0, exc_req}, 1);

    summary();
  end
endmodule